// File: doc/BRIEF.md
# Programmable Wakeup Down-Counter

This block is a periodic wakeup timer. A down-counter runs on a selectable tick. The tick is either the kernel clock divided by 16, 8, 4 or 2, or an external once-per-second enable pulse. The counter is reloaded from a 16-bit value. In an extended mode, 65535 is added to that value, which gives a 17-bit count. Each time the counter expires it sets a sticky wakeup flag and emits a one-cycle event pulse. An interrupt output mirrors the flag when interrupts are enabled.

Software writes the tick-select code and the reload value while the timer is stopped. A write-allowed output reports when such writes take effect. The enable input is a level: its rising edge loads the counter, and holding it high keeps the timer running. The 1 Hz tick is generated elsewhere and arrives as a single-cycle enable pulse. The event output has a programmable polarity so that it can drive a pin directly.

Top module: `wakeup_timer`

## Requirements
- R1: After reset, wr_ok_o is 1, flag_o is 0, irq_o is 0, and evt_o sits at its idle level, which equals evt_pol_i.
- R2: Select codes 0, 1, 2 and 3 tick the counter every 16, 8, 4 and 2 kernel clocks. The first expiry is registered at the clock edge D*(reload+1) edges after the edge that samples enable_i high. D is the divisor.
- R3: When select-code bit 2 is set, each high cycle of tick_1hz_i is one tick. Codes 4 and 5 count the reload value. Codes 6 and 7 count the reload value plus 65535.
- R4: On each expiry the counter reloads, so later expiries repeat with the same period for as long as enable_i stays high.
- R5: wr_ok_o is 1 exactly when the timer was stopped at the previous clock edge. A configuration write (cfg_we_i) is ignored while wr_ok_o is 0.
- R6: flag_o is set at each expiry and stays set until flag_clr_i is sampled high. When an expiry and a clear fall in the same cycle, the expiry wins.
- R7: irq_o is high only while flag_o is high and irq_en_i is high.
- R8: evt_o is active for exactly the one cycle after each expiry. With evt_pol_i = 0 the active level is high and the idle level is low. With evt_pol_i = 1 the levels are reversed.
- R9: A reload value of 0 in a 16-bit count mode expires on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz_i | input | 1 | Once-per-second tick, one cycle wide |
| enable_i | input | 1 | Run level; its rising edge loads the counter |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Tick-select code |
| cfg_reload_i | input | 16 | Reload value |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Wakeup flag clear |
| evt_pol_i | input | 1 | Event polarity, 1 = active low |
| wr_ok_o | output | 1 | Configuration writes take effect |
| flag_o | output | 1 | Sticky wakeup flag |
| irq_o | output | 1 | Wakeup interrupt |
| evt_o | output | 1 | Wakeup event pulse |

## Verification
The assertions assume that evt_pol_i is stable and that configuration is written only through cfg_we_i. They also assume that enable_i is a level, not a strobe, which is what the register-stability property relies on.

The stimulus changes evt_pol_i and the configuration only while the timer is stopped, apart from the one deliberate write made while running. tick_1hz_i is either held high as a tick on every cycle or pulsed with idle gaps between pulses. flag_clr_i is asserted for single cycles, except where a held clear tests whether an expiry takes priority over a clear.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    localparam int unsigned RELOAD_W = 16;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned PRE_W    = 4;
    localparam int unsigned NUM_DIV  = 4;

    // Decoded tick selection
    typedef struct packed {
        logic       slow;   // use the external once-per-second tick
        logic       ext;    // add the extension constant to the reload
        logic [1:0] div;    // prescaler tap: 0 -> /16 ... 3 -> /2
    } tick_sel_t;

    function automatic tick_sel_t decode_sel(input logic [SEL_W-1:0] code);
        tick_sel_t r;
        r.slow = code[2];
        r.ext  = code[2] & code[1];
        r.div  = code[1:0];
        return r;
    endfunction

endpackage

// File: rtl/wkt_cfg.sv
module wkt_cfg
    import wkt_pkg::*;
#(
    parameter int unsigned RW = RELOAD_W,
    parameter int unsigned SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          we_i,
    input  logic [SW-1:0] sel_i,
    input  logic [RW-1:0] reload_i,
    output logic          run_o,
    output logic          start_o,
    output logic          wr_ok_o,
    output logic [SW-1:0] sel_o,
    output logic [RW-1:0] reload_o
);

    typedef struct packed {
        logic          run;
        logic [SW-1:0] sel;
        logic [RW-1:0] reload;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = enable_i;
        if (we_i && !st_q.run) begin
            st_d.sel    = sel_i;
            st_d.reload = reload_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o    = st_q.run;
    assign start_o  = enable_i && !st_q.run;
    assign wr_ok_o  = !st_q.run;
    // Forwarded so a write in the start cycle is seen by the load
    assign sel_o    = st_d.sel;
    assign reload_o = st_d.reload;

endmodule

// File: rtl/wkt_prescaler.sv
module wkt_prescaler
    import wkt_pkg::*;
#(
    parameter int unsigned PW = PRE_W,
    parameter int unsigned ND = NUM_DIV
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  slow_i,
    input  logic [$clog2(ND)-1:0] div_i,
    input  logic                  pulse_i,
    output logic                  tick_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [ND-1:0] tap;

    // Tap g fires when the low PW-g bits are all ones: period 2^(PW-g)
    for (genvar g = 0; g < ND; g++) begin : g_tap
        assign tap[g] = &st_q.cnt[PW-1-g:0];
    end

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
        tick_o = run_i && (slow_i ? pulse_i : tap[div_i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wkt_counter.sv
module wkt_counter
    import wkt_pkg::*;
#(
    parameter int unsigned RW = RELOAD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          tick_i,
    input  logic          ext_i,
    input  logic [RW-1:0] reload_i,
    output logic          expire_o
);

    localparam int unsigned CNT_W   = RW + 1;
    localparam int unsigned EXT_ADD = (1 << RW) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] eff;
    logic             at_zero;

    always_comb begin
        eff      = {1'b0, reload_i} + (ext_i ? CNT_W'(EXT_ADD) : '0);
        at_zero  = (st_q.cnt == '0);
        expire_o = tick_i && at_zero && !start_i;
        st_d     = st_q;
        if (start_i) begin
            st_d.cnt = eff;
        end else if (tick_i) begin
            st_d.cnt = at_zero ? eff : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wkt_event.sv
module wkt_event (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    input  logic irq_en_i,
    input  logic pol_i,
    output logic flag_o,
    output logic irq_o,
    output logic evt_o
);

    typedef struct packed {
        logic flag;
        logic pulse;
    } evt_state_t;

    evt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = expire_i;
        if (expire_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & irq_en_i;
    assign evt_o  = st_q.pulse ^ pol_i;

endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer
    import wkt_pkg::*;
#(
    parameter int unsigned RW = RELOAD_W,
    parameter int unsigned SW = SEL_W,
    parameter int unsigned PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1hz_i,
    input  logic          enable_i,
    input  logic          cfg_we_i,
    input  logic [SW-1:0] cfg_sel_i,
    input  logic [RW-1:0] cfg_reload_i,
    input  logic          irq_en_i,
    input  logic          flag_clr_i,
    input  logic          evt_pol_i,
    output logic          wr_ok_o,
    output logic          flag_o,
    output logic          irq_o,
    output logic          evt_o
);

    logic          run;
    logic          start;
    logic [SW-1:0] cfg_sel;
    logic [RW-1:0] cfg_reload;
    tick_sel_t     tsel;
    logic          tick;
    logic          expire;

    wkt_cfg #(.RW(RW), .SW(SW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .we_i     (cfg_we_i),
        .sel_i    (cfg_sel_i),
        .reload_i (cfg_reload_i),
        .run_o    (run),
        .start_o  (start),
        .wr_ok_o  (wr_ok_o),
        .sel_o    (cfg_sel),
        .reload_o (cfg_reload)
    );

    assign tsel = decode_sel(cfg_sel);

    wkt_prescaler #(.PW(PW), .ND(NUM_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .slow_i  (tsel.slow),
        .div_i   (tsel.div),
        .pulse_i (tick_1hz_i),
        .tick_o  (tick)
    );

    wkt_counter #(.RW(RW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .tick_i   (tick),
        .ext_i    (tsel.ext),
        .reload_i (cfg_reload),
        .expire_o (expire)
    );

    wkt_event u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clr_i    (flag_clr_i),
        .irq_en_i (irq_en_i),
        .pol_i    (evt_pol_i),
        .flag_o   (flag_o),
        .irq_o    (irq_o),
        .evt_o    (evt_o)
    );

endmodule

// File: rtl/wakeup_timer_chk.sv
module wakeup_timer_chk #(
    parameter int unsigned RW = 16,
    parameter int unsigned SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable_i,
    input logic          flag_clr_i,
    input logic          irq_en_i,
    input logic          evt_pol_i,
    input logic          wr_ok_o,
    input logic          flag_o,
    input logic          irq_o,
    input logic          evt_o,
    input logic [SW-1:0] sel_q,
    input logic [RW-1:0] reload_q
);

    // R5
    run_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i |=> !wr_ok_o);

    // R5
    stop_allows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> wr_ok_o);

    // R5
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok_o && enable_i) |=> ($stable(reload_q) && $stable(sel_q)));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);

    // R6
    flag_rise_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> (evt_o != evt_pol_i));

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en_i && flag_o));

    // R8
    evt_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o != evt_pol_i) |-> flag_o);

endmodule

bind wakeup_timer wakeup_timer_chk #(.RW(RW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .flag_clr_i (flag_clr_i),
    .irq_en_i   (irq_en_i),
    .evt_pol_i  (evt_pol_i),
    .wr_ok_o    (wr_ok_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .evt_o      (evt_o),
    .sel_q      (cfg_sel),
    .reload_q   (cfg_reload)
);

// File: tb/wakeup_timer_test.sv
module wakeup_timer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_1hz_i;
    logic        enable_i;
    logic        cfg_we_i;
    logic [2:0]  cfg_sel_i;
    logic [15:0] cfg_reload_i;
    logic        irq_en_i;
    logic        flag_clr_i;
    logic        evt_pol_i;
    logic        wr_ok_o;
    logic        flag_o;
    logic        irq_o;
    logic        evt_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wakeup_timer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_1hz_i   (tick_1hz_i),
        .enable_i     (enable_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_sel_i    (cfg_sel_i),
        .cfg_reload_i (cfg_reload_i),
        .irq_en_i     (irq_en_i),
        .flag_clr_i   (flag_clr_i),
        .evt_pol_i    (evt_pol_i),
        .wr_ok_o      (wr_ok_o),
        .flag_o       (flag_o),
        .irq_o        (irq_o),
        .evt_o        (evt_o)
    );

    // per = expected clocks from the start edge to the first expiry edge
    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] rl;
        logic        pol;
        logic [17:0] per;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 16'd3, 1'b0, 18'd64},
        '{3'd1, 16'd5, 1'b1, 18'd48},
        '{3'd2, 16'd0, 1'b0, 18'd4},
        '{3'd3, 16'd9, 1'b1, 18'd20},
        '{3'd4, 16'd7, 1'b0, 18'd8},
        '{3'd5, 16'd1, 1'b1, 18'd2},
        '{3'd6, 16'd2, 1'b0, 18'd65538},
        '{3'd7, 16'd0, 1'b1, 18'd65536}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic [2:0] sel, input logic [15:0] rl, input logic pol);
        @(negedge clk);
        enable_i = 1'b0;
        repeat (2) @(negedge clk);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i   = 1'b0;
        cfg_we_i     = 1'b1;
        cfg_sel_i    = sel;
        cfg_reload_i = rl;
        evt_pol_i    = pol;
        tick_1hz_i   = sel[2];
        @(negedge clk);
        cfg_we_i = 1'b0;
        chk(wr_ok_o == 1'b1, "R5 wr_ok while stopped", int'(wr_ok_o), 1);
    endtask

    task automatic run_vec(input vec_t v);
        string req;
        int    p;
        req = v.sel[2] ? "R3 first expiry" : "R2 first expiry";
        p   = int'(v.per);
        enable_i = 1'b1;
        repeat (p) @(posedge clk);
        @(negedge clk);
        chk(flag_o == 1'b0, req, int'(flag_o), 0);
        chk(evt_o == v.pol, "R8 idle before expiry", int'(evt_o), int'(v.pol));
        @(posedge clk);
        @(negedge clk);
        chk(flag_o == 1'b1, req, int'(flag_o), 1);
        chk(evt_o == !v.pol, "R8 active at expiry", int'(evt_o), int'(!v.pol));
        if (p >= 4 && p < 1000) begin
            @(posedge clk);
            @(negedge clk);
            chk(evt_o == v.pol, "R8 one-cycle pulse", int'(evt_o), int'(v.pol));
            flag_clr_i = 1'b1;
            @(negedge clk);
            flag_clr_i = 1'b0;
            chk(flag_o == 1'b0, "R6 cleared", int'(flag_o), 0);
            repeat (p - 3) @(posedge clk);
            @(negedge clk);
            chk(flag_o == 1'b0, "R4 before second expiry", int'(flag_o), 0);
            @(posedge clk);
            @(negedge clk);
            chk(flag_o == 1'b1, "R4 second expiry", int'(flag_o), 1);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst_n        = 1'b0;
        tick_1hz_i   = 1'b0;
        enable_i     = 1'b0;
        cfg_we_i     = 1'b0;
        cfg_sel_i    = '0;
        cfg_reload_i = '0;
        irq_en_i     = 1'b0;
        flag_clr_i   = 1'b0;
        evt_pol_i    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wr_ok_o == 1'b1, "R1 wr_ok", int'(wr_ok_o), 1);
        chk(flag_o == 1'b0, "R1 flag", int'(flag_o), 0);
        chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
        chk(evt_o == 1'b0, "R1 evt idle", int'(evt_o), 0);
        evt_pol_i = 1'b1;
        #1;
        chk(evt_o == 1'b1, "R1 evt idle low-active", int'(evt_o), 1);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            setup(VECS[i].sel, VECS[i].rl, VECS[i].pol);
            run_vec(VECS[i]);
        end

        // R5: a write while running is ignored
        setup(3'd3, 16'd9, 1'b0);
        enable_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(wr_ok_o == 1'b0, "R5 wr_ok while running", int'(wr_ok_o), 0);
        cfg_we_i     = 1'b1;
        cfg_sel_i    = 3'd0;
        cfg_reload_i = 16'd1;
        @(posedge clk);
        @(negedge clk);
        cfg_we_i = 1'b0;
        repeat (18) @(posedge clk);
        @(negedge clk);
        chk(flag_o == 1'b0, "R5 period unchanged (early)", int'(flag_o), 0);
        @(posedge clk);
        @(negedge clk);
        chk(flag_o == 1'b1, "R5 period unchanged (expiry)", int'(flag_o), 1);
        enable_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(wr_ok_o == 1'b1, "R5 wr_ok after stop", int'(wr_ok_o), 1);

        // R7: interrupt gating
        chk(irq_o == 1'b0, "R7 irq masked", int'(irq_o), 0);
        irq_en_i = 1'b1;
        #1;
        chk(irq_o == 1'b1, "R7 irq enabled", int'(irq_o), 1);
        @(negedge clk);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
        chk(flag_o == 1'b0, "R6 clear", int'(flag_o), 0);
        chk(irq_o == 1'b0, "R7 irq follows flag", int'(irq_o), 0);

        // R9 and R6: reload 0 expires each tick; expiry beats clear
        setup(3'd4, 16'd0, 1'b0);
        enable_i = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(flag_o == 1'b1, "R9 expiry on first tick", int'(flag_o), 1);
        chk(evt_o == 1'b1, "R9 evt first tick", int'(evt_o), 1);
        flag_clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(flag_o == 1'b1, "R6 set wins over clear", int'(flag_o), 1);
        chk(evt_o == 1'b1, "R9 evt every tick", int'(evt_o), 1);
        enable_i = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(flag_o == 1'b0, "R6 clear after stop", int'(flag_o), 0);
        flag_clr_i = 1'b0;

        // R3: sparse once-per-second pulses
        setup(3'd4, 16'd2, 1'b0);
        tick_1hz_i = 1'b0;
        enable_i   = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            repeat (4) @(negedge clk);
            tick_1hz_i = 1'b1;
            @(negedge clk);
            tick_1hz_i = 1'b0;
            chk(flag_o == (p == 2), "R3 sparse ticks", int'(flag_o), int'(p == 2));
        end

        finish_run();
    end

endmodule